// File: doc/BRIEF.md
# Transmitter Key Load Sequencer

This block brings the transmitter's secret key set out of fuse storage and into key storage before link authentication begins. A single-cycle start request runs one sequence. If the key store already reports its keys as loaded and valid, the sequence finishes at once and fires no trigger. Otherwise the block fires a load trigger and waits for the store's load-done flag, bounded by a timeout. It then reads the load-success flag. A failed attempt is followed by a clear of the keys and their status flags, then another attempt, up to a fixed limit. A good load ends with one pulse that forwards the public key to the link side.

Two inputs gate the sequence. A power-good input must be high when the start request is accepted, or the sequence ends in error straight away. A mode input marks parts whose keys are loaded by hardware with no request. In that mode a missing load-done flag is an error and no trigger is fired. The done and error results stay on their outputs until the next accepted start. An attempt counter reports how many load triggers the last sequence fired.

Top module: `keyld_seq`

## Requirements
- R1: While reset is held and after it is released, every trigger output, done and error are low and the attempt count is 0.
- R2: A start accepted while power-good is low raises error in the next cycle, fires no trigger and leaves the attempt count at 0.
- R3: If load-done and load-success are both high in the cycle after start, done rises in the cycle after that, with no load trigger, no clear trigger and no send pulse.
- R4: Each load attempt fires a load trigger that lasts exactly one cycle, and the attempt count rises by one in the cycle after it.
- R5: An attempt fails when load-done has not been seen high at any of the TMO_CYC clock edges that follow the load-trigger cycle. TMO_CYC is (CLK_HZ / 1,000,000) × TIMEOUT_US.
- R6: An attempt also fails when load-done is high but load-success is low at the edge where it is sampled.
- R7: When an attempt fails and attempts remain, a one-cycle clear trigger follows. It tells the store to erase the keys and drop load-done, load-success and the three fuse status flags. A new load trigger fires in the next cycle.
- R8: After MAX_TRIES failed attempts, error rises, the attempt count equals MAX_TRIES and no further trigger fires. The count never exceeds MAX_TRIES.
- R9: A successful attempt fires exactly one send-public-key pulse, and done rises in the cycle after it.
- R10: In automatic-load mode, a low load-done in the cycle after start raises error, with no trigger fired.
- R11: Done and error hold their values until the next accepted start. A start that arrives while a sequence is running is ignored.
- R12: Done and error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| auto_mode_i | input | 1 | Keys are loaded by hardware; no trigger allowed |
| pwr_ok_i | input | 1 | Power domain for key loading is on |
| ld_done_i | input | 1 | Key store reports the load has finished |
| ld_ok_i | input | 1 | Key store reports the loaded keys are valid |
| load_trig_o | output | 1 | One-cycle key-load trigger |
| clear_trig_o | output | 1 | One-cycle clear of keys and key status flags |
| send_pub_o | output | 1 | One-cycle send-public-key trigger |
| done_o | output | 1 | Sequence finished successfully (held) |
| err_o | output | 1 | Sequence finished in error (held) |
| attempts_o | output | clog2(MAX_TRIES+1) | Load triggers fired in the current sequence |

## Verification
The load-done flag and the expiry of the timeout can land on the same clock edge. In that case the arriving flag must win, so the attempt is judged on load-success and not counted as a timeout. The bench sets the key-store latency to exactly TMO_CYC cycles and then to one more. The first run must succeed on a single attempt. The second must time out, clear and succeed on its retry, with each cycle compared against the behavioural model. A start pulse that lands in the middle of a wait is also checked against the model, to show it has no effect.

// File: rtl/keyld_pkg.sv
package keyld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOAD,
        ST_WAIT,
        ST_CLEAR,
        ST_SEND
    } kl_state_e;

    // Flags reported by the key store
    typedef struct packed {
        logic done;
        logic ok;
    } kl_flags_t;

    // Trigger pulses towards key store and link side
    typedef struct packed {
        logic load;
        logic clear;
        logic send;
    } kl_pulse_t;

    // Outcome of one attempt, evaluated while waiting
    typedef enum logic [1:0] {
        AT_PENDING,
        AT_PASS,
        AT_FAIL
    } kl_attempt_e;

    function automatic int unsigned tmo_cycles(input int unsigned hz, input int unsigned us);
        int unsigned c;
        c = (hz / 1_000_000) * us;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/keyld_timer.sv
module keyld_timer
    import keyld_pkg::*;
#(
    parameter int unsigned TMO_CYC = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int unsigned W = cnt_width(TMO_CYC);

    logic [W-1:0] cnt;

    assign expired = (cnt == W'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    timer_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R5
    timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/keyld_tries.sv
module keyld_tries
    import keyld_pkg::*;
#(
    parameter int unsigned MAX_TRIES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic [cnt_width(MAX_TRIES + 1)-1:0] count,
    output logic last
);
    localparam int unsigned W = cnt_width(MAX_TRIES + 1);

    assign last = (count == W'(MAX_TRIES));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && !last) begin
            count <= count + 1'b1;
        end
    end

    // R4
    tries_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !last) |=> (count == $past(count) + 1'b1));

    // R8
    tries_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= W'(MAX_TRIES));

endmodule

// File: rtl/keyld_fsm.sv
module keyld_fsm
    import keyld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      auto_i,
    input  logic      pwr_ok_i,
    input  kl_flags_t flags,
    input  logic      tmo_hit,
    input  logic      tries_last,
    output kl_pulse_t pulse,
    output logic      timer_clr,
    output logic      timer_en,
    output logic      tries_clr,
    output logic      tries_inc,
    output logic      done_o,
    output logic      err_o
);
    kl_state_e   st, nxt;
    kl_attempt_e outcome;
    logic        accept, set_done, set_err;

    // Result of the attempt being waited on; a flag on the expiry edge wins
    always_comb begin
        if (flags.done && flags.ok)      outcome = AT_PASS;
        else if (flags.done || tmo_hit)  outcome = AT_FAIL;
        else                             outcome = AT_PENDING;
    end

    always_comb begin
        nxt      = st;
        accept   = 1'b0;
        set_done = 1'b0;
        set_err  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_i) begin
                    accept = 1'b1;
                    if (pwr_ok_i) nxt = ST_CHECK;
                    else          set_err = 1'b1;
                end
            end
            ST_CHECK: begin
                if (flags.done && flags.ok) begin
                    set_done = 1'b1;
                    nxt      = ST_IDLE;
                end else if (auto_i && !flags.done) begin
                    set_err = 1'b1;
                    nxt     = ST_IDLE;
                end else begin
                    nxt = ST_LOAD;
                end
            end
            ST_LOAD:  nxt = ST_WAIT;
            ST_WAIT: begin
                if (outcome == AT_PASS) begin
                    nxt = ST_SEND;
                end else if (outcome == AT_FAIL) begin
                    if (tries_last) begin
                        set_err = 1'b1;
                        nxt     = ST_IDLE;
                    end else begin
                        nxt = ST_CLEAR;
                    end
                end
            end
            ST_CLEAR: nxt = ST_LOAD;
            ST_SEND: begin
                set_done = 1'b1;
                nxt      = ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            done_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            st <= nxt;
            if (accept) begin
                done_o <= 1'b0;
                err_o  <= set_err;
            end else begin
                if (set_done) done_o <= 1'b1;
                if (set_err)  err_o  <= 1'b1;
            end
        end
    end

    assign pulse.load  = (st == ST_LOAD);
    assign pulse.clear = (st == ST_CLEAR);
    assign pulse.send  = (st == ST_SEND);
    assign timer_clr   = pulse.load;
    assign timer_en    = (st == ST_WAIT);
    assign tries_clr   = accept;
    assign tries_inc   = pulse.load;

    // R2
    pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start_i && !pwr_ok_i) |=> (err_o && st == ST_IDLE));

    // R10
    auto_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK && auto_i && !flags.done) |=> (err_o && !pulse.load));

    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && start_i && outcome == AT_PENDING) |=> (st == ST_WAIT));

endmodule

// File: rtl/keyld_seq.sv
module keyld_seq
    import keyld_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 500,
    parameter int unsigned MAX_TRIES  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic auto_mode_i,
    input  logic pwr_ok_i,
    input  logic ld_done_i,
    input  logic ld_ok_i,
    output logic load_trig_o,
    output logic clear_trig_o,
    output logic send_pub_o,
    output logic done_o,
    output logic err_o,
    output logic [cnt_width(MAX_TRIES + 1)-1:0] attempts_o
);
    localparam int unsigned TMO_CYC = tmo_cycles(CLK_HZ, TIMEOUT_US);

    kl_flags_t flags;
    kl_pulse_t pulse;
    logic      tmo_hit, tries_last;
    logic      timer_clr, timer_en, tries_clr, tries_inc;

    assign flags.done = ld_done_i;
    assign flags.ok   = ld_ok_i;

    keyld_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .auto_i    (auto_mode_i),
        .pwr_ok_i  (pwr_ok_i),
        .flags     (flags),
        .tmo_hit   (tmo_hit),
        .tries_last(tries_last),
        .pulse     (pulse),
        .timer_clr (timer_clr),
        .timer_en  (timer_en),
        .tries_clr (tries_clr),
        .tries_inc (tries_inc),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    keyld_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (timer_clr),
        .en     (timer_en),
        .expired(tmo_hit)
    );

    keyld_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (tries_clr),
        .inc  (tries_inc),
        .count(attempts_o),
        .last (tries_last)
    );

    assign load_trig_o  = pulse.load;
    assign clear_trig_o = pulse.clear;
    assign send_pub_o   = pulse.send;

    // R4
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_trig_o |=> !load_trig_o);

    // R7
    clear_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        clear_trig_o |=> load_trig_o);

    // R9
    send_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        send_pub_o |=> (done_o && !send_pub_o));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

    // R12
    result_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

endmodule

// File: tb/keyld_seq_tb.sv
module keyld_seq_tb;
    localparam int CLK_HZ = 50_000_000;
    localparam int TMO_US = 2;
    localparam int MAX    = 5;
    localparam int TMO    = (CLK_HZ / 1_000_000) * TMO_US;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, auto_m = 1'b0, pwr = 1'b1;
    logic ld_done = 1'b0, ld_ok = 1'b0;
    logic load_t, clr_t, send_t, done_w, err_w;
    logic [2:0] att;

    keyld_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TMO_US), .MAX_TRIES(MAX)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .auto_mode_i(auto_m), .pwr_ok_i(pwr),
        .ld_done_i(ld_done), .ld_ok_i(ld_ok), .load_trig_o(load_t), .clear_trig_o(clr_t),
        .send_pub_o(send_t), .done_o(done_w), .err_o(err_w), .attempts_o(att)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit ended = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle,1 check,2 load,3 wait,4 clear,5 send
    int m_ph = 0, m_tmr = 0, m_att = 0;
    bit m_done = 0, m_err = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_tmr = 0; m_att = 0; m_done = 0; m_err = 0;
        end else begin
            case (m_ph)
                0: if (start) begin
                       m_done = 0; m_err = 0; m_att = 0;
                       if (pwr) m_ph = 1; else m_err = 1;
                   end
                1: if (ld_done && ld_ok) begin m_done = 1; m_ph = 0; end
                   else if (auto_m && !ld_done) begin m_err = 1; m_ph = 0; end
                   else m_ph = 2;
                2: begin m_att++; m_tmr = 0; m_ph = 3; end
                3: if (ld_done && ld_ok) m_ph = 5;
                   else if (ld_done || m_tmr == TMO - 1) begin
                       if (m_att == MAX) begin m_err = 1; m_ph = 0; end
                       else m_ph = 4;
                   end else m_tmr++;
                4: m_ph = 2;
                5: begin m_done = 1; m_ph = 0; end
                default: m_ph = 0;
            endcase
        end
    end

    // Key store model and per-cycle comparison
    int lat_q[$];
    bit ok_q[$];
    int env_cnt = -1;
    bit env_ok = 0;
    int n_load = 0, n_clear = 0, n_send = 0;

    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk("R4 load pulse", int'(load_t), int'(m_ph == 2));
            chk("R7 clear pulse", int'(clr_t), int'(m_ph == 4));
            chk("R9 send pulse", int'(send_t), int'(m_ph == 5));
            chk("R11 done", int'(done_w), int'(m_done));
            chk("R11 err", int'(err_w), int'(m_err));
            chk("R8 attempts", int'(att), m_att);
        end
        if (load_t) begin
            n_load++;
            env_cnt = (lat_q.size() > 0) ? lat_q.pop_front() : -1;
            env_ok  = (ok_q.size() > 0) ? ok_q.pop_front() : 1'b0;
        end else if (env_cnt > 0) begin
            env_cnt--;
            if (env_cnt == 0) begin
                ld_done = 1'b1;
                ld_ok   = env_ok;
                env_cnt = -1;
            end
        end
        if (clr_t) begin
            n_clear++;
            ld_done = 1'b0; ld_ok = 1'b0; env_cnt = -1;
        end
        if (send_t) n_send++;
    end

    task automatic prep();
        @(negedge clk);
        ld_done = 1'b0; ld_ok = 1'b0; env_cnt = -1;
        lat_q.delete(); ok_q.delete();
        n_load = 0; n_clear = 0; n_send = 0;
    endtask

    task automatic add(input int lat, input bit ok);
        lat_q.push_back(lat);
        ok_q.push_back(ok);
    endtask

    task automatic go(input int stray_at);
        int wd;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wd = 0;
        while (!(done_w || err_w) && wd < 5000) begin
            @(negedge clk);
            wd++;
            start = (wd == stray_at);
        end
        start = 1'b0;
        if (wd >= 5000) chk("R11 sequence ended", 0, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 load", int'(load_t), 0);
        chk("R1 done/err", int'(done_w || err_w), 0);
        chk("R1 attempts", int'(att), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 after release", int'(load_t || clr_t || send_t || done_w || err_w), 0);

        // R2 power low
        prep(); pwr = 1'b0;
        go(0);
        chk("R2 err", int'(err_w), 1);
        chk("R2 no load", n_load, 0);
        chk("R2 attempts", int'(att), 0);
        pwr = 1'b1;

        // R3 keys already present
        prep(); ld_done = 1'b1; ld_ok = 1'b1;
        go(0);
        chk("R3 done", int'(done_w), 1);
        chk("R3 no triggers", n_load + n_clear + n_send, 0);

        // R4 R9 plain success
        prep(); add(3, 1);
        go(0);
        chk("R4 one load", n_load, 1);
        chk("R9 one send", n_send, 1);
        chk("R9 done", int'(done_w), 1);

        // R6 R7 bad keys then success
        prep(); add(2, 0); add(4, 1);
        go(0);
        chk("R6 attempts", int'(att), 2);
        chk("R7 one clear", n_clear, 1);
        chk("R6 done", int'(done_w), 1);

        // R5 timeout then success
        prep(); add(-1, 0); add(1, 1);
        go(0);
        chk("R5 attempts", int'(att), 2);
        chk("R5 done", int'(done_w), 1);

        // R8 exhaustion
        prep(); add(-1, 0); add(2, 0); add(-1, 0); add(5, 0); add(1, 0);
        go(0);
        chk("R8 err", int'(err_w), 1);
        chk("R8 attempts", int'(att), MAX);
        chk("R8 loads", n_load, MAX);
        chk("R8 clears", n_clear, MAX - 1);
        repeat (5) @(negedge clk);
        chk("R8 no more loads", n_load, MAX);

        // R10 auto mode, keys missing
        prep(); auto_m = 1'b1;
        go(0);
        chk("R10 err", int'(err_w), 1);
        chk("R10 no load", n_load, 0);
        auto_m = 1'b0;

        // R5 boundary: flag on expiry edge wins
        prep(); add(TMO, 1);
        go(0);
        chk("R5 edge pass attempts", int'(att), 1);
        chk("R5 edge done", int'(done_w), 1);
        prep(); add(TMO + 1, 1); add(2, 1);
        go(0);
        chk("R5 one past edge attempts", int'(att), 2);
        chk("R5 one past edge clears", n_clear, 1);

        // R11 stray start during wait, then hold
        prep(); add(20, 1);
        go(6);
        chk("R11 stray start loads", n_load, 1);
        chk("R11 done", int'(done_w), 1);
        repeat (10) @(negedge clk);
        chk("R11 done held", int'(done_w), 1);
        chk("R12 exclusive", int'(done_w && err_w), 0);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule